// File: doc/BRIEF.md
# Subblock Write-Through Data Cache

A direct-mapped data cache whose lines are divided into one-word subblocks. Each subblock has its own valid bit, while a single address tag covers the whole line. The cache is write-through: every CPU write is forwarded to memory in the same cycle on a word-wide write port. A write never waits for a line to be fetched. If the tag does not match, the write takes over the line at once: it installs its own tag, marks its own word valid and invalidates the other words of the line.

Reads are answered combinationally from the tag, valid and data arrays. A read hits only when the line tag matches and the addressed subblock is valid. When a read misses in the idle state, the cache raises a single-cycle refill request for that one word and enters a waiting state. When the refill response arrives, the word is installed, unless a write has touched the same line in the meantime. The CPU retries the read after the refill.

The controller has two states. `ST_IDLE` is the normal state. `ST_WAIT` means one refill is outstanding. There are two transitions:
- `miss_issue` (`ST_IDLE` to `ST_WAIT`): a read misses in `ST_IDLE`.
- `fill_done` (`ST_WAIT` to `ST_IDLE`): a refill response arrives.

In every other case the state holds.

Top module: `swt_cache`

## Requirements
- R1: Reset clears every valid bit, so any read issued after reset reports a miss (cpu_hit=0, cpu_miss=1).
- R2: Addresses are word addresses. Bits [1:0] select the word, bits [7:2] select the line and bits [31:8] form the tag. A read hits (cpu_hit=1, cpu_rdata = stored word) only if the line tag equals the address tag and that word's valid bit is set. Otherwise it reports cpu_miss=1 and cpu_hit=0.
- R3: A write whose tag matches and whose word is already valid overwrites that word, and the word stays valid.
- R4: A write whose tag matches and whose word is invalid stores the word and sets its valid bit. The other words of the line are unchanged.
- R5: A write whose tag does not match replaces the line tag and marks the written word valid. It marks the other three words invalid, all in the same cycle.
- R6: Every write drives mem_wr_en=1, with mem_wr_addr and mem_wr_data equal to the CPU address and data, in the cycle of the write. Writes are accepted in both states.
- R7: A read miss in ST_IDLE raises fill_req for exactly one cycle, with fill_addr equal to the read address, and moves to ST_WAIT. Read misses in ST_WAIT raise no request.
- R8: A refill response (fill_valid) in ST_WAIT installs fill_data at the pending address, using the same tag rule as a write, and returns to ST_IDLE. Only the requested word becomes valid.
- R9: A refill response is discarded if any write to the same line index was made while waiting or is made in the same cycle as the response. The write's effect is kept.
- R10: A word written in one cycle is returned, as a hit, by a read of the same address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd_req | input | 1 | CPU read request (exclusive with write) |
| cpu_wr_req | input | 1 | CPU write request |
| cpu_addr | input | 32 | CPU word address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Read data, valid when cpu_hit is high |
| cpu_hit | output | 1 | Read hit |
| cpu_miss | output | 1 | Read miss |
| mem_wr_en | output | 1 | Write-through strobe to memory |
| mem_wr_addr | output | 32 | Write-through word address |
| mem_wr_data | output | 32 | Write-through data |
| fill_req | output | 1 | One-cycle refill request |
| fill_addr | output | 32 | Word address of the refill |
| fill_valid | input | 1 | Refill response strobe |
| fill_data | input | 32 | Refill word |

## Verification
A CPU write and a refill response can land in the same cycle, and both want to update tag, valid and data state.

The bench drives a refill response and a write together, in two cases:
- The write goes to the pending line. The write's word must then hit and the refilled word must still miss.
- The write goes to a different line. Both words must then hit on the following reads.

A third case places the write one cycle before the response, to check that the discard is remembered across the waiting state.

// File: rtl/swt_pkg.sv
package swt_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } swt_state_e;
endpackage

// File: rtl/swt_tag_store.sv
module swt_tag_store #(
    parameter int LINES = 64,
    parameter int WPL   = 4,
    parameter int TAG_W = 24,
    parameter int IDX_W = 6,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic [WPL-1:0]   rd_vld,
    input  logic             a_en,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [TAG_W-1:0] a_tag,
    input  logic [SEL_W-1:0] a_sel,
    input  logic             b_en,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [TAG_W-1:0] b_tag,
    input  logic [SEL_W-1:0] b_sel
);
    logic [TAG_W-1:0] tag_w [LINES];
    logic [WPL-1:0]   vld_w [LINES];
    logic [WPL-1:0]   a_oh, b_oh;

    assign a_oh = WPL'(1) << a_sel;
    assign b_oh = WPL'(1) << b_sel;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic a_here, b_here;
        assign a_here = a_en && (a_idx == IDX_W'(g));
        assign b_here = b_en && (b_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_w[g] <= '0;
                vld_w[g] <= '0;
            end else if (a_here) begin
                if (tag_w[g] == a_tag) begin
                    vld_w[g] <= vld_w[g] | a_oh;
                end else begin
                    tag_w[g] <= a_tag;
                    vld_w[g] <= a_oh;
                end
            end else if (b_here) begin
                if (tag_w[g] == b_tag) begin
                    vld_w[g] <= vld_w[g] | b_oh;
                end else begin
                    tag_w[g] <= b_tag;
                    vld_w[g] <= b_oh;
                end
            end
        end
    end

    assign rd_tag = tag_w[rd_idx];
    assign rd_vld = vld_w[rd_idx];
endmodule

// File: rtl/swt_data_store.sv
module swt_data_store #(
    parameter int WORD_W = 32,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              a_en,
    input  logic [PTR_W-1:0]  a_ptr,
    input  logic [WORD_W-1:0] a_data,
    input  logic              b_en,
    input  logic [PTR_W-1:0]  b_ptr,
    input  logic [WORD_W-1:0] b_data
);
    localparam int DEPTH = 1 << PTR_W;

    logic [WORD_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (b_en) word_q[b_ptr] <= b_data;
        if (a_en) word_q[a_ptr] <= a_data;
    end

    assign rd_data = word_q[rd_ptr];
endmodule

// File: rtl/swt_ctrl.sv
module swt_ctrl
    import swt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              rd_hit,
    input  logic              wr_req,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              fill_valid,
    output logic              fill_req,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              install_en
);
    swt_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pend_q;
    logic              stale_q;
    logic [IDX_W-1:0]  pend_idx;
    logic              wr_same_line;

    assign pend_idx     = pend_q[IDX_W+SEL_W-1:SEL_W];
    assign wr_same_line = wr_req && (wr_idx == pend_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            stale_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fill_req) begin
                pend_q  <= cpu_addr;
                stale_q <= 1'b0;
            end else if (state_q == ST_WAIT && wr_same_line) begin
                stale_q <= 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req && !rd_hit) state_d = ST_WAIT;
            ST_WAIT: if (fill_valid)        state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fill_req   = 1'b0;
        install_en = 1'b0;
        unique case (state_q)
            ST_IDLE: fill_req   = rd_req && !rd_hit;
            ST_WAIT: install_en = fill_valid && !stale_q && !wr_same_line;
            default: ;
        endcase
    end

    assign pend_addr = pend_q;
endmodule

// File: rtl/swt_cache.sv
module swt_cache #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int LINES  = 64,
    parameter int WPL    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd_req,
    input  logic              cpu_wr_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_miss,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [WORD_W-1:0] fill_data
);
    localparam int SEL_W = $clog2(WPL);
    localparam int IDX_W = $clog2(LINES);
    localparam int PTR_W = IDX_W + SEL_W;
    localparam int TAG_W = ADDR_W - PTR_W;

    logic [TAG_W-1:0]  rd_tag;
    logic [WPL-1:0]    rd_vld;
    logic [WORD_W-1:0] rd_word;
    logic [ADDR_W-1:0] pend_addr;
    logic              install_en;
    logic              hit_c;

    wire [SEL_W-1:0] a_sel = cpu_addr[SEL_W-1:0];
    wire [IDX_W-1:0] a_idx = cpu_addr[PTR_W-1:SEL_W];
    wire [TAG_W-1:0] a_tag = cpu_addr[ADDR_W-1:PTR_W];

    swt_tag_store #(
        .LINES(LINES), .WPL(WPL), .TAG_W(TAG_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) tags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (a_idx),
        .rd_tag (rd_tag),
        .rd_vld (rd_vld),
        .a_en   (cpu_wr_req),
        .a_idx  (a_idx),
        .a_tag  (a_tag),
        .a_sel  (a_sel),
        .b_en   (install_en),
        .b_idx  (pend_addr[PTR_W-1:SEL_W]),
        .b_tag  (pend_addr[ADDR_W-1:PTR_W]),
        .b_sel  (pend_addr[SEL_W-1:0])
    );

    swt_data_store #(.WORD_W(WORD_W), .PTR_W(PTR_W)) data_i (
        .clk     (clk),
        .rd_ptr  (cpu_addr[PTR_W-1:0]),
        .rd_data (rd_word),
        .a_en    (cpu_wr_req),
        .a_ptr   (cpu_addr[PTR_W-1:0]),
        .a_data  (cpu_wdata),
        .b_en    (install_en),
        .b_ptr   (pend_addr[PTR_W-1:0]),
        .b_data  (fill_data)
    );

    assign hit_c = cpu_rd_req && (rd_tag == a_tag) && rd_vld[a_sel];

    swt_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (cpu_rd_req),
        .rd_hit     (hit_c),
        .wr_req     (cpu_wr_req),
        .wr_idx     (a_idx),
        .cpu_addr   (cpu_addr),
        .fill_valid (fill_valid),
        .fill_req   (fill_req),
        .pend_addr  (pend_addr),
        .install_en (install_en)
    );

    assign cpu_hit     = hit_c;
    assign cpu_miss    = cpu_rd_req && !hit_c;
    assign cpu_rdata   = rd_word;
    assign fill_addr   = cpu_addr;
    assign mem_wr_en   = cpu_wr_req;
    assign mem_wr_addr = cpu_addr;
    assign mem_wr_data = cpu_wdata;
endmodule

// File: rtl/swt_cache_chk.sv
module swt_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd_req,
    input logic              cpu_wr_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [WORD_W-1:0] cpu_wdata,
    input logic [WORD_W-1:0] cpu_rdata,
    input logic              cpu_hit,
    input logic              cpu_miss,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [WORD_W-1:0] mem_wr_data,
    input logic              fill_req
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R2
    hit_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (cpu_rd_req && !cpu_miss));

    // R6
    write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_req |-> (mem_wr_en && mem_wr_addr == cpu_addr && mem_wr_data == cpu_wdata));

    // R7
    single_fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> !fill_req);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && cpu_rd_req) |-> !cpu_hit);

    // R10
    write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(cpu_wr_req) && cpu_rd_req && cpu_addr == $past(cpu_addr))
        |-> (cpu_hit && cpu_rdata == $past(cpu_wdata)));
endmodule

bind swt_cache swt_cache_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chk_i (.*);

// File: tb/swt_cache_tb.sv
`timescale 1ns/1ps
module swt_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd_req = 1'b0, cpu_wr_req = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata, mem_wr_addr, mem_wr_data, fill_addr;
    logic        cpu_hit, cpu_miss, mem_wr_en, fill_req;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    swt_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd_req(cpu_rd_req), .cpu_wr_req(cpu_wr_req),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_hit(cpu_hit), .cpu_miss(cpu_miss),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    // Vector: {op(1: write), addr(32), data(32), expected hit(1)}
    // Address = tag<<8 | line<<2 | word
    localparam int NV = 17;
    localparam logic [65:0] VEC [NV] = '{
        {1'b0, 32'h0000010C, 32'h00000000, 1'b0}, // R1 empty after reset
        {1'b1, 32'h0000010C, 32'h000000A1, 1'b0}, // R5 write miss allocates
        {1'b0, 32'h0000010C, 32'h000000A1, 1'b1}, // R10 next-cycle visibility
        {1'b0, 32'h0000010D, 32'h00000000, 1'b0}, // R2 neighbour word invalid
        {1'b1, 32'h0000010D, 32'h000000B2, 1'b0}, // R4 match, invalid word
        {1'b0, 32'h0000010D, 32'h000000B2, 1'b1}, // R4
        {1'b0, 32'h0000010C, 32'h000000A1, 1'b1}, // R4 other word untouched
        {1'b1, 32'h0000010C, 32'h000000C3, 1'b0}, // R3 match, valid word
        {1'b0, 32'h0000010C, 32'h000000C3, 1'b1}, // R3
        {1'b1, 32'h0000020E, 32'h000000D4, 1'b0}, // R5 tag mismatch
        {1'b0, 32'h0000020E, 32'h000000D4, 1'b1}, // R5
        {1'b0, 32'h0000010C, 32'h00000000, 1'b0}, // R5 old tag gone
        {1'b0, 32'h0000020C, 32'h00000000, 1'b0}, // R5 others cleared
        {1'b0, 32'h0000020D, 32'h00000000, 1'b0}, // R5 others cleared
        {1'b1, 32'h00000510, 32'h000000E5, 1'b0}, // R6 another line
        {1'b0, 32'h00000510, 32'h000000E5, 1'b1}, // R2
        {1'b0, 32'h0000020E, 32'h000000D4, 1'b1}  // R2 other line unaffected
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on the falling edge; return 1.5 ns later, before the rising edge.
    task automatic drive(input logic rd, input logic wr, input logic [31:0] a,
                         input logic [31:0] wd, input logic fv, input logic [31:0] fd);
        @(negedge clk);
        cpu_rd_req = rd; cpu_wr_req = wr; cpu_addr = a; cpu_wdata = wd;
        fill_valid = fv; fill_data = fd;
        #1.5;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, '0, '0, 1'b0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        cpu_rd_req = 1'b0; cpu_wr_req = 1'b0; fill_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic expect_read(input string req, input logic [31:0] a,
                               input logic exp_hit, input logic [31:0] exp_data);
        drive(1'b1, 1'b0, a, '0, 1'b0, '0);
        check(req, {31'b0, cpu_hit}, {31'b0, exp_hit});
        check(req, {31'b0, cpu_miss}, {31'b0, !exp_hit});
        if (exp_hit) check(req, cpu_rdata, exp_data);
    endtask

    initial begin
        do_reset();

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic        op;
            logic [31:0] a, d;
            logic        h;
            op = VEC[i][65]; a = VEC[i][64:33]; d = VEC[i][32:1]; h = VEC[i][0];
            drive(!op, op, a, d, 1'b0, '0);
            if (op) begin
                check("R6 mem_wr_en", {31'b0, mem_wr_en}, 32'd1);
                check("R6 mem_wr_addr", mem_wr_addr, a);
                check("R6 mem_wr_data", mem_wr_data, d);
            end else begin
                check("R2 hit", {31'b0, cpu_hit}, {31'b0, h});
                check("R2 miss", {31'b0, cpu_miss}, {31'b0, !h});
                check("R6 no write on read", {31'b0, mem_wr_en}, 32'd0);
                if (h) check("R2 rdata", cpu_rdata, d);
            end
        end

        // R1: reset clears a previously valid word
        do_reset();
        expect_read("R1 after reset", 32'h00000510, 1'b0, '0);

        // R7 / R8: refill request and install
        do_reset();
        drive(1'b1, 1'b0, 32'h00000320, '0, 1'b0, '0);
        check("R7 fill_req", {31'b0, fill_req}, 32'd1);
        check("R7 fill_addr", fill_addr, 32'h00000320);
        drive(1'b1, 1'b0, 32'h000003A0, '0, 1'b0, '0);
        check("R7 no second request while waiting", {31'b0, fill_req}, 32'd0);
        drive(1'b0, 1'b1, 32'h00000404, 32'h00001111, 1'b0, '0);
        check("R6 write accepted while waiting", {31'b0, mem_wr_en}, 32'd1);
        drive(1'b0, 1'b0, '0, '0, 1'b1, 32'h000000F6);
        expect_read("R8 refilled word", 32'h00000320, 1'b1, 32'h000000F6);
        expect_read("R8 only requested word valid", 32'h00000321, 1'b0, '0);
        check("R8 back to idle", {31'b0, fill_req}, 32'd1);
        expect_read("R10 write during wait kept", 32'h00000404, 1'b1, 32'h00001111);

        // R9: refill and write to the same line in one cycle
        do_reset();
        drive(1'b1, 1'b0, 32'h00000324, '0, 1'b0, '0);
        check("R9 request", {31'b0, fill_req}, 32'd1);
        drive(1'b0, 1'b1, 32'h00000325, 32'h00000055, 1'b1, 32'h00000077);
        check("R6 write with refill", mem_wr_data, 32'h00000055);
        expect_read("R9 write wins", 32'h00000325, 1'b1, 32'h00000055);
        expect_read("R9 refill dropped", 32'h00000324, 1'b0, '0);

        // R8: refill and write to different lines in one cycle
        do_reset();
        drive(1'b1, 1'b0, 32'h00000328, '0, 1'b0, '0);
        drive(1'b0, 1'b1, 32'h00000330, 32'h00000099, 1'b1, 32'h00000088);
        expect_read("R8 refill alongside write", 32'h00000328, 1'b1, 32'h00000088);
        expect_read("R8 write alongside refill", 32'h00000330, 1'b1, 32'h00000099);

        // R9: write to the pending line one cycle before the response
        do_reset();
        drive(1'b1, 1'b0, 32'h00000334, '0, 1'b0, '0);
        drive(1'b0, 1'b1, 32'h00000337, 32'h000000AB, 1'b0, '0);
        drive(1'b0, 1'b0, '0, '0, 1'b1, 32'h000000CD);
        expect_read("R9 stale refill dropped", 32'h00000334, 1'b0, '0);
        expect_read("R9 earlier write kept", 32'h00000337, 1'b1, 32'h000000AB);

        idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule